// File: doc/BRIEF.md
# C/A Spreading-Code Replica Generator

This block produces the local spreading-code replicas that one satellite receiver channel correlates against incoming front-end samples. A 32-bit phase accumulator adds a programmable step on every valid sample. Each carry out of the accumulator moves the replica on by one chip of a 1023-chip Gold sequence, which is chosen by a satellite index. Three taps of that sequence, half a chip apart, drive the early, prompt and late correlators. When the last chip of the sequence ends, the block emits a one-cycle period strobe. Downstream accumulators use it to dump their sums.

The loop filters compute a new step from the accumulations of one period. The block holds that value in a pending register and applies it only when the next period ends, so a step always runs for whole periods. During sequential code-offset search, an enable input makes the block throw away the sample that follows each period boundary. This slides the replica one sample against the input stream without any sample memory. A counter at the ports records how many samples have been dropped. A re-align command returns the generator to chip 0 with a cleared phase. It takes effect on the next valid sample.

Top module: `ca_replica_gen`

## Requirements
- R1: Every valid sample adds the active step to a 32-bit phase. A carry out of bit 31 advances `chip_idx` by one. With a step of 2^30 the index therefore rises once every 4 samples, starting from reset. Steps above 2^31 are not supported.
- R2: Cycles with `sample_vld` low change none of `chip_idx`, `chip_e`, `chip_p`, `chip_l`, `epoch`.
- R3: The chip sequence is a 1023-chip Gold code. G1 is 1+x^3+x^10 and G2 is 1+x^2+x^3+x^6+x^8+x^9+x^10, and both start all ones. Each chip is the last G1 stage XOR two G2 stages picked by the satellite. `prn_sel` value v selects satellite v+1. The first ten chips, written MSB first as octal, are 1440, 1620, 1710, 1744 and 1133 for values 0 to 4. The sequence restarts at chip 0 every period. `prn_sel` is changed only around a reset or re-align.
- R4: Each phase-MSB transition shifts the newest code bit into a 3-stage tap line. That means a mid-chip 0-to-1 transition or the carry. On a carry, the bit of the new chip is shifted in. `chip_e` is the newest stage, `chip_p` the middle and `chip_l` the oldest. With step 2^30, after 4k samples the taps read E=c(k) and P=L=c(k-1). After 4k+2 samples they read E=P=c(k) and L=c(k-1).
- R5: The sample that carries out of chip 1022 wraps `chip_idx` to 0. In the next cycle `epoch` is high for exactly one clock.
- R6: `step_wr` stores `step_val` in a pending register. The active step takes the pending value stored before the wrapping sample, at that sample. So a new step first affects the sample after the period boundary.
- R7: When `skip_en` is high on a wrapping sample, the next valid sample leaves the phase, chip and taps unchanged, and `skip_cnt` increases by one. When `skip_en` is low, no sample is dropped and `skip_cnt` holds.
- R8: A `realign` pulse is remembered. The next valid sample then clears the phase and `chip_idx` and reloads the LFSRs. It also fills all three taps with chip 0, which is 1 for every satellite, and it does not advance the NCO. Before that sample nothing changes.
- R9: After synchronous reset: `chip_idx`=0, `epoch`=0, `skip_cnt`=0, all three taps 1, and both step registers hold 2^30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_vld | input | 1 | One front-end sample arrives this cycle |
| prn_sel | input | 5 | Satellite select, value v means satellite v+1 |
| step_wr | input | 1 | Write `step_val` into the pending step register |
| step_val | input | 32 | New phase step, at most 2^31 |
| realign | input | 1 | Request a return to chip 0 on the next valid sample |
| skip_en | input | 1 | Drop the sample after each period boundary |
| chip_e | output | 1 | Early replica chip |
| chip_p | output | 1 | Prompt replica chip |
| chip_l | output | 1 | Late replica chip |
| epoch | output | 1 | One-cycle strobe after the last chip of a period |
| chip_idx | output | 10 | Index of the chip the generator currently sits on |
| skip_cnt | output | 16 | Number of samples dropped for code search |

## Verification
A wrong LFSR tap or seed shows on `chip_e` within the first ten chips after reset or re-align. That is at most 40 samples at the quarter-chip step, and it is compared against the published octal chip prefixes. An error in the tap line, or in the order between a carry and a shift, shows two samples later as `chip_p` or `chip_l` disagreeing with the half-chip relation. A wrong period length, a premature step load or a mis-armed sample drop stays hidden until the first period boundary. There it moves `epoch`, `chip_idx` or `skip_cnt` by one sample or one chip, so the bench runs full 4092-sample periods and samples on both sides of the boundary.

// File: rtl/gps_code_pkg.sv
package gps_code_pkg;

    localparam int LFSR_W = 10;
    localparam int PRN_W  = 5;

    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef struct packed {
        logic [3:0] a;
        logic [3:0] b;
    } tap_pair_t;

    typedef struct packed {
        logic e;
        logic p;
        logic l;
    } epl_t;

    // stage n of a register lives in bit n-1; shifting moves toward stage 10
    function automatic lfsr_t g1_adv(lfsr_t s);
        return {s[8:0], s[2] ^ s[9]};
    endfunction

    function automatic lfsr_t g2_adv(lfsr_t s);
        return {s[8:0], s[1] ^ s[2] ^ s[5] ^ s[7] ^ s[8] ^ s[9]};
    endfunction

    // G2 stage pair per satellite, returned as bit indices
    function automatic tap_pair_t prn_taps(logic [PRN_W-1:0] sel);
        logic [7:0] st;
        tap_pair_t  t;
        case (sel)
            5'd0:  st = {4'd2, 4'd6};
            5'd1:  st = {4'd3, 4'd7};
            5'd2:  st = {4'd4, 4'd8};
            5'd3:  st = {4'd5, 4'd9};
            5'd4:  st = {4'd1, 4'd9};
            5'd5:  st = {4'd2, 4'd10};
            5'd6:  st = {4'd1, 4'd8};
            5'd7:  st = {4'd2, 4'd9};
            5'd8:  st = {4'd3, 4'd10};
            5'd9:  st = {4'd2, 4'd3};
            5'd10: st = {4'd3, 4'd4};
            5'd11: st = {4'd5, 4'd6};
            5'd12: st = {4'd6, 4'd7};
            5'd13: st = {4'd7, 4'd8};
            5'd14: st = {4'd8, 4'd9};
            5'd15: st = {4'd9, 4'd10};
            5'd16: st = {4'd1, 4'd4};
            5'd17: st = {4'd2, 4'd5};
            5'd18: st = {4'd3, 4'd6};
            5'd19: st = {4'd4, 4'd7};
            5'd20: st = {4'd5, 4'd8};
            5'd21: st = {4'd6, 4'd9};
            5'd22: st = {4'd1, 4'd3};
            5'd23: st = {4'd4, 4'd6};
            5'd24: st = {4'd5, 4'd7};
            5'd25: st = {4'd6, 4'd8};
            5'd26: st = {4'd7, 4'd9};
            5'd27: st = {4'd8, 4'd10};
            5'd28: st = {4'd1, 4'd6};
            5'd29: st = {4'd2, 4'd7};
            5'd30: st = {4'd3, 4'd8};
            default: st = {4'd4, 4'd9};
        endcase
        t.a = st[7:4] - 4'd1;
        t.b = st[3:0] - 4'd1;
        return t;
    endfunction

    function automatic logic gold_bit(lfsr_t g1, lfsr_t g2, tap_pair_t t);
        return g1[9] ^ g2[t.a] ^ g2[t.b];
    endfunction

endpackage

// File: rtl/code_nco.sv
module code_nco #(
    parameter int              W        = 32,
    parameter logic [W-1:0]    STEP_RST = 32'h4000_0000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         clr,
    input  logic         step_wr,
    input  logic [W-1:0] step_val,
    input  logic         load_step,
    output logic         ovf,
    output logic         half
);
    logic [W-1:0] phase_q;
    logic [W-1:0] step_act_q;
    logic [W-1:0] step_pend_q;
    logic [W:0]   sum;

    always_comb begin
        sum  = {1'b0, phase_q} + {1'b0, step_act_q};
        ovf  = adv & sum[W];
        half = adv & ~phase_q[W-1] & sum[W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= '0;
            step_act_q  <= STEP_RST;
            step_pend_q <= STEP_RST;
        end else begin
            if (step_wr)
                step_pend_q <= step_val;
            if (load_step)
                step_act_q <= step_pend_q;
            if (clr)
                phase_q <= '0;
            else if (adv)
                phase_q <= sum[W-1:0];
        end
    end
endmodule

// File: rtl/gold_seq.sv
module gold_seq
    import gps_code_pkg::*;
#(
    parameter int CODE_LEN = 1023,
    parameter int CNT_W    = $clog2(CODE_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             clr,
    input  logic [PRN_W-1:0] prn_sel,
    output logic             bit_now,
    output logic             bit_next,
    output logic             bit_seed,
    output logic             last,
    output logic [CNT_W-1:0] idx
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CODE_LEN - 1);

    lfsr_t     g1_q, g2_q;
    tap_pair_t taps;

    always_comb begin
        taps     = prn_taps(prn_sel);
        last     = (idx == LAST_IDX);
        bit_seed = gold_bit('1, '1, taps);
        bit_now  = gold_bit(g1_q, g2_q, taps);
        bit_next = last ? bit_seed : gold_bit(g1_adv(g1_q), g2_adv(g2_q), taps);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            g1_q <= '1;
            g2_q <= '1;
            idx  <= '0;
        end else if (step) begin
            if (last) begin
                g1_q <= '1;
                g2_q <= '1;
                idx  <= '0;
            end else begin
                g1_q <= g1_adv(g1_q);
                g2_q <= g2_adv(g2_q);
                idx  <= idx + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/epl_taps.sv
module epl_taps
    import gps_code_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic seed,
    input  logic push,
    input  logic din,
    output epl_t taps
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            taps <= '{e: seed, p: seed, l: seed};
        else if (push)
            taps <= '{e: din, p: taps.e, l: taps.p};
    end
endmodule

// File: rtl/ca_replica_gen.sv
module ca_replica_gen
    import gps_code_pkg::*;
#(
    parameter int                 NCO_W    = 32,
    parameter int                 CODE_LEN = 1023,
    parameter int                 OFS_W    = 16,
    parameter logic [NCO_W-1:0]   STEP_RST = 32'h4000_0000,
    localparam int                CNT_W    = $clog2(CODE_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_vld,
    input  logic [PRN_W-1:0] prn_sel,
    input  logic             step_wr,
    input  logic [NCO_W-1:0] step_val,
    input  logic             realign,
    input  logic             skip_en,
    output logic             chip_e,
    output logic             chip_p,
    output logic             chip_l,
    output logic             epoch,
    output logic [CNT_W-1:0] chip_idx,
    output logic [OFS_W-1:0] skip_cnt
);
    logic realign_pend_q, drop_pend_q;
    logic adv, realign_now, drop_now, epoch_now;
    logic ovf, half;
    logic bit_now, bit_next, bit_seed, last;
    epl_t taps;

    always_comb begin
        realign_now = sample_vld & realign_pend_q;
        drop_now    = sample_vld & drop_pend_q & ~realign_pend_q;
        adv         = sample_vld & ~realign_pend_q & ~drop_pend_q;
        epoch_now   = ovf & last;
    end

    code_nco #(.W(NCO_W), .STEP_RST(STEP_RST)) u_nco (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .clr       (realign_now),
        .step_wr   (step_wr),
        .step_val  (step_val),
        .load_step (epoch_now),
        .ovf       (ovf),
        .half      (half)
    );

    gold_seq #(.CODE_LEN(CODE_LEN), .CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .step     (ovf),
        .clr      (realign_now),
        .prn_sel  (prn_sel),
        .bit_now  (bit_now),
        .bit_next (bit_next),
        .bit_seed (bit_seed),
        .last     (last),
        .idx      (chip_idx)
    );

    epl_taps u_taps (
        .clk  (clk),
        .rst  (rst),
        .clr  (realign_now),
        .seed (bit_seed),
        .push (ovf | half),
        .din  (ovf ? bit_next : bit_now),
        .taps (taps)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            realign_pend_q <= 1'b0;
            drop_pend_q    <= 1'b0;
            skip_cnt       <= '0;
            epoch          <= 1'b0;
        end else begin
            epoch          <= epoch_now;
            realign_pend_q <= realign | (realign_pend_q & ~sample_vld);
            if (realign_now || drop_now)
                drop_pend_q <= 1'b0;
            else if (epoch_now && skip_en)
                drop_pend_q <= 1'b1;
            if (drop_now)
                skip_cnt <= skip_cnt + OFS_W'(1);
        end
    end

    assign chip_e = taps.e;
    assign chip_p = taps.p;
    assign chip_l = taps.l;
endmodule

// File: rtl/ca_replica_gen_chk.sv
module ca_replica_gen_chk #(
    parameter int CNT_W = 10,
    parameter int OFS_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             sample_vld,
    input logic             chip_e,
    input logic             chip_p,
    input logic             chip_l,
    input logic             epoch,
    input logic [CNT_W-1:0] chip_idx,
    input logic [OFS_W-1:0] skip_cnt
);
    a_r5_epoch_at_chip_zero: assert property (@(posedge clk) disable iff (rst)
        epoch |-> chip_idx == '0);

    a_r5_epoch_single_cycle: assert property (@(posedge clk) disable iff (rst)
        epoch |=> !epoch);

    a_r2_epoch_needs_sample: assert property (@(posedge clk) disable iff (rst)
        epoch |-> $past(sample_vld));

    a_r2_hold_without_sample: assert property (@(posedge clk) disable iff (rst)
        !sample_vld |=> $stable(chip_idx) && $stable(chip_e) && $stable(chip_p) && $stable(chip_l));

    a_r1_chip_steps_by_one: assert property (@(posedge clk) disable iff (rst)
        !$stable(chip_idx) |-> (chip_idx == $past(chip_idx) + CNT_W'(1)) || (chip_idx == '0));

    a_r7_offset_steps_by_one: assert property (@(posedge clk) disable iff (rst)
        !$stable(skip_cnt) |-> (skip_cnt == $past(skip_cnt) + OFS_W'(1)) && $past(sample_vld));
endmodule

bind ca_replica_gen ca_replica_gen_chk #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sample_vld (sample_vld),
    .chip_e     (chip_e),
    .chip_p     (chip_p),
    .chip_l     (chip_l),
    .epoch      (epoch),
    .chip_idx   (chip_idx),
    .skip_cnt   (skip_cnt)
);

// File: tb/ca_replica_gen_bench.sv
module ca_replica_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_vld = 1'b0;
    logic [4:0]  prn_sel = 5'd0;
    logic        step_wr = 1'b0;
    logic [31:0] step_val = 32'd0;
    logic        realign = 1'b0;
    logic        skip_en = 1'b0;
    logic        chip_e, chip_p, chip_l, epoch;
    logic [9:0]  chip_idx;
    logic [15:0] skip_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // {prn_sel, first ten chips MSB first}
    localparam logic [14:0] GOLD_TAB [5] = '{
        {5'd0, 10'o1440},
        {5'd1, 10'o1620},
        {5'd2, 10'o1710},
        {5'd3, 10'o1744},
        {5'd4, 10'o1133}
    };

    ca_replica_gen u_ca_replica_gen (
        .clk        (clk),
        .rst        (rst),
        .sample_vld (sample_vld),
        .prn_sel    (prn_sel),
        .step_wr    (step_wr),
        .step_val   (step_val),
        .realign    (realign),
        .skip_en    (skip_en),
        .chip_e     (chip_e),
        .chip_p     (chip_p),
        .chip_l     (chip_l),
        .epoch      (epoch),
        .chip_idx   (chip_idx),
        .skip_cnt   (skip_cnt)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic feed(input int n);
        for (int i = 0; i < n; i++) begin
            sample_vld = 1'b1;
            @(negedge clk);
        end
        sample_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
    endtask

    function automatic logic ch(input int row, input int k);
        return GOLD_TAB[row][9-k];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic e_hold;
        @(negedge clk);

        // R9 reset state
        do_reset();
        chk("R9 chip_idx", 32'(chip_idx), 0);
        chk("R9 epoch", 32'(epoch), 0);
        chk("R9 skip_cnt", 32'(skip_cnt), 0);
        chk("R9 taps", 32'({chip_e, chip_p, chip_l}), 32'h7);

        // R3 R4 R1: table walk over satellites, step 2^30
        for (int r = 0; r < 5; r++) begin
            prn_sel = GOLD_TAB[r][14:10];
            do_reset();
            chk("R3 chip0 on E", 32'(chip_e), 32'(ch(r, 0)));
            for (int k = 1; k < 10; k++) begin
                feed(2);
                chk("R4 mid-chip P", 32'(chip_p), 32'(ch(r, k-1)));
                chk("R4 mid-chip E", 32'(chip_e), 32'(ch(r, k-1)));
                feed(2);
                chk("R3 chip on E", 32'(chip_e), 32'(ch(r, k)));
                chk("R4 chip start L", 32'(chip_l), 32'(ch(r, k-1)));
                chk("R1 chip_idx", 32'(chip_idx), 32'(k));
            end
        end

        // R2 gapped samples, idle cycles and a step write change nothing
        prn_sel = 5'd0;
        do_reset();
        for (int i = 0; i < 4; i++) begin
            sample_vld = 1'b1;
            @(negedge clk);
            sample_vld = 1'b0;
            @(negedge clk);
        end
        chk("R2 gapped advance", 32'(chip_idx), 1);
        e_hold = chip_e;
        step_wr = 1'b1; step_val = 32'h8000_0000;
        @(negedge clk);
        step_wr = 1'b0;
        idle(5);
        chk("R2 idle chip_idx", 32'(chip_idx), 1);
        chk("R2 idle chip_e", 32'(chip_e), 32'(e_hold));
        chk("R2 idle epoch", 32'(epoch), 0);

        // R5 R6 period boundary and deferred step
        do_reset();
        step_wr = 1'b1; step_val = 32'h8000_0000;
        @(negedge clk);
        step_wr = 1'b0;
        feed(8);
        chk("R6 old step still active", 32'(chip_idx), 2);
        feed(4083);
        chk("R5 before wrap chip_idx", 32'(chip_idx), 1022);
        chk("R5 before wrap epoch", 32'(epoch), 0);
        feed(1);
        chk("R5 epoch high", 32'(epoch), 1);
        chk("R5 wrap chip_idx", 32'(chip_idx), 0);
        chk("R3 restart chip0", 32'(chip_e), 1);
        idle(1);
        chk("R5 epoch one cycle", 32'(epoch), 0);
        chk("R7 no drop when disabled", 32'(skip_cnt), 0);
        feed(2);
        chk("R6 new step after boundary", 32'(chip_idx), 1);
        chk("R3 period two chip1", 32'(chip_e), 32'(ch(0, 1)));
        for (int k = 2; k < 10; k++) begin
            feed(2);
            chk("R3 period two chip", 32'(chip_e), 32'(ch(0, k)));
        end

        // R7 sample drop after boundary
        do_reset();
        skip_en = 1'b1;
        feed(4092);
        chk("R7 boundary epoch", 32'(epoch), 1);
        chk("R7 count before drop", 32'(skip_cnt), 0);
        feed(1);
        chk("R7 count after drop", 32'(skip_cnt), 1);
        chk("R7 dropped sample chip_idx", 32'(chip_idx), 0);
        feed(3);
        chk("R7 shifted by one chip_idx", 32'(chip_idx), 0);
        feed(1);
        chk("R7 shifted chip arrives", 32'(chip_idx), 1);
        chk("R7 single drop", 32'(skip_cnt), 1);
        skip_en = 1'b0;

        // R8 re-align
        do_reset();
        feed(22);
        chk("R8 pre chip_idx", 32'(chip_idx), 5);
        realign = 1'b1;
        @(negedge clk);
        realign = 1'b0;
        idle(2);
        chk("R8 waits for sample", 32'(chip_idx), 5);
        feed(1);
        chk("R8 chip_idx cleared", 32'(chip_idx), 0);
        chk("R8 taps refilled", 32'({chip_e, chip_p, chip_l}), 32'h7);
        feed(4);
        chk("R8 phase cleared", 32'(chip_idx), 1);
        chk("R8 chip1", 32'(chip_e), 32'(ch(0, 1)));
        feed(4);
        chk("R8 chip2", 32'(chip_e), 32'(ch(0, 2)));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule